// File: doc/BRIEF.md
# Monitor Interrupt Aggregation Controller

This block merges every interrupt source of a hardware-monitoring device into one active-low interrupt pin. It keeps a status register and a mask register for each source group behind a small register read/write port. Analog/temperature out-of-limit results and fan under-speed results are captured at the end of their own monitoring cycles and feed sticky latches. GPIO inputs, a high GPIO line and the chassis-intrusion input follow their level and are never latched. Thermal-output transitions and fan start/stop transitions produce one-shot events.

Software enables the pin in the configuration register and clears it in one of three ways: reading the analog status register, holding the configuration clear bit, or an alert-response-address hit. A latched channel that has been cleared discards the partial monitoring cycle in progress and can only fire again at the end of the next full cycle of its own type. Level sources ignore every clear and drop out only when masked or removed.

Top module: `mon_irq_agg`

## Requirements
- R1: After reset the interrupt pin is high (inactive) and the configuration, status and mask registers all read zero.
- R2: The pin is low only while configuration bit 1 (enable) is 1, configuration bit 2 (clear) is 0 and at least one unmasked source is pending.
- R3: On each analog cycle-end pulse the analog status register (address 1) loads the analog compare results; when armed, an unmasked set bit sets the analog latch. Mask bit 1 means masked (address 5).
- R4: On each fan cycle-end pulse the fan status register (address 2) loads the under-speed flags; when armed, an unmasked set bit sets the fan latch (mask at address 6).
- R5: A read of address 1 clears the analog, fan and event status bits and all three interrupt latches in the following cycle.
- R6: An alert-response strobe whose 7-bit address equals 0001100 clears all interrupt latches; any other address has no effect.
- R7: While configuration bit 2 is 1 the latches are held cleared and the pin stays high.
- R8: After any clear, the first cycle-end pulse of a latched channel only re-arms it; the second one can set its latch again.
- R9: GPIO inputs (status address 4, mask address 8), the high GPIO line (misc status bit 7) and intrusion (misc status bit 6) drive the pin by level; no clear affects them; setting the mask bit or removing the input releases the pin.
- R10: Either edge of the thermal input sets misc status (address 3) bit 3 and the event latch; a steady level does not set it again after a clear.
- R11: With configuration bit 4 set, either edge of the fan-running input sets misc bit 4 and the event latch; misc bit 4 self-clears at the next fan cycle end; with bit 4 clear such edges are ignored.
- R12: Masked sources still record status but never drive the pin (misc mask at address 7 uses the same bit positions as misc status).
- R13: Configuration (address 0) and mask registers write and read back all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (one cycle) |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| analogEnd | input | 1 | End of analog monitoring cycle |
| analogOor | input | NUM_AN | Analog/temperature out-of-limit flags |
| fanEnd | input | 1 | End of fan monitoring cycle |
| fanSlow | input | NUM_FAN | Fan under-speed flags |
| gpioIn | input | NUM_GPIO | GPIO inputs, polarity already applied |
| gpioHi | input | 1 | Additional high GPIO line |
| intrusion | input | 1 | Chassis-intrusion level |
| thermIn | input | 1 | Thermal output level |
| fanRunning | input | 1 | Fan running indication |
| araValid | input | 1 | Alert-response address strobe |
| araAddr | input | 7 | Address received with the strobe |
| irqN | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with eight analog, eight fan and eight GPIO sources, so every status and mask register fills its full byte and masks with mixed bit patterns (upper nibble, lower nibble, alternating bits) reach each source group. With that width a table of mixed analog, fan and GPIO patterns shows masked and unmasked bits side by side, and directed sequences reach the discarded first cycle after a clear, the wrong alert address, the held clear bit and steady thermal levels after a clear.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CFG       = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT_AN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT_FAN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_STAT_MISC = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT_GPIO = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK_AN   = 4'd5;
  localparam logic [ADDR_W-1:0] A_MASK_FAN  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MASK_MISC = 4'd7;
  localparam logic [ADDR_W-1:0] A_MASK_GPIO = 4'd8;

  localparam int CFG_EN      = 1;
  localparam int CFG_CLR     = 2;
  localparam int CFG_AUTOFAN = 4;

  localparam int MISC_THERM  = 3;
  localparam int MISC_FANCHG = 4;
  localparam int MISC_INTR   = 6;
  localparam int MISC_GPIOHI = 7;

  typedef struct packed {
    logic statRead;
    logic araHit;
    logic wrCfg;
    logic wrMaskAn;
    logic wrMaskFan;
    logic wrMaskMisc;
    logic wrMaskGpio;
    logic thermEdge;
    logic fanEdge;
  } ctrl_strobe_t;
endpackage

// File: rtl/mon_irq_chan.sv
module mon_irq_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cycleEnd,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] mask,
  input  logic         statClear,
  input  logic         irqClear,
  output logic [W-1:0] status,
  output logic         latch,
  output logic         armed
);
  logic hit;
  assign hit = |(sample & ~mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      latch  <= 1'b0;
      armed  <= 1'b1;
    end else begin
      if (cycleEnd)       status <= sample;
      else if (statClear) status <= '0;

      if (irqClear) begin
        latch <= 1'b0;
        armed <= 1'b0;
      end else if (cycleEnd) begin
        if (armed && hit) latch <= 1'b1;
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mon_irq_ctrl.sv
module mon_irq_ctrl
  import mon_irq_pkg::*;
#(
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              araValid,
  input  logic [6:0]        araAddr,
  input  logic              thermIn,
  input  logic              fanRunning,
  output ctrl_strobe_t      strb
);
  logic thermPrev, fanPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      thermPrev <= 1'b0;
      fanPrev   <= 1'b0;
    end else begin
      thermPrev <= thermIn;
      fanPrev   <= fanRunning;
    end
  end

  always_comb begin
    strb            = '0;
    strb.statRead   = rdEn && (addr == A_STAT_AN);
    strb.araHit     = araValid && (araAddr == ARA_ADDR);
    strb.wrCfg      = wrEn && (addr == A_CFG);
    strb.wrMaskAn   = wrEn && (addr == A_MASK_AN);
    strb.wrMaskFan  = wrEn && (addr == A_MASK_FAN);
    strb.wrMaskMisc = wrEn && (addr == A_MASK_MISC);
    strb.wrMaskGpio = wrEn && (addr == A_MASK_GPIO);
    strb.thermEdge  = thermIn ^ thermPrev;
    strb.fanEdge    = fanRunning ^ fanPrev;
  end
endmodule

// File: rtl/mon_irq_dp.sv
module mon_irq_dp
  import mon_irq_pkg::*;
#(
  parameter int NUM_AN   = 8,
  parameter int NUM_FAN  = 8,
  parameter int NUM_GPIO = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrl_strobe_t        strb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                analogEnd,
  input  logic [NUM_AN-1:0]   analogOor,
  input  logic                fanEnd,
  input  logic [NUM_FAN-1:0]  fanSlow,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  logic                gpioHi,
  input  logic                intrusion,
  output logic                irqN
);
  logic [DATA_W-1:0] cfgReg, maskAn, maskFan, maskMisc, maskGpio;
  logic [NUM_AN-1:0]  statAn;
  logic [NUM_FAN-1:0] statFan;
  logic anLatch, anArmed, fanLatch, fanArmed;
  logic thermChg, fanChg, evLatch;
  logic irqClear, fanEv, evSet, levelIrq, pending;
  logic [DATA_W-1:0] statAnPad, statFanPad, statGpioPad, statMisc;

  assign irqClear = strb.statRead | strb.araHit | cfgReg[CFG_CLR];
  assign fanEv    = strb.fanEdge & cfgReg[CFG_AUTOFAN];
  assign evSet    = (strb.thermEdge & ~maskMisc[MISC_THERM]) |
                    (fanEv & ~maskMisc[MISC_FANCHG]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg   <= '0;
      maskAn   <= '0;
      maskFan  <= '0;
      maskMisc <= '0;
      maskGpio <= '0;
    end else begin
      if (strb.wrCfg)      cfgReg   <= wrData;
      if (strb.wrMaskAn)   maskAn   <= wrData;
      if (strb.wrMaskFan)  maskFan  <= wrData;
      if (strb.wrMaskMisc) maskMisc <= wrData;
      if (strb.wrMaskGpio) maskGpio <= wrData;
    end
  end

  mon_irq_chan #(.W(NUM_AN)) u_an (
    .clk(clk), .rst(rst), .cycleEnd(analogEnd), .sample(analogOor),
    .mask(maskAn[NUM_AN-1:0]), .statClear(strb.statRead), .irqClear(irqClear),
    .status(statAn), .latch(anLatch), .armed(anArmed)
  );

  mon_irq_chan #(.W(NUM_FAN)) u_fan (
    .clk(clk), .rst(rst), .cycleEnd(fanEnd), .sample(fanSlow),
    .mask(maskFan[NUM_FAN-1:0]), .statClear(strb.statRead), .irqClear(irqClear),
    .status(statFan), .latch(fanLatch), .armed(fanArmed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thermChg <= 1'b0;
      fanChg   <= 1'b0;
      evLatch  <= 1'b0;
    end else begin
      if (strb.thermEdge)    thermChg <= 1'b1;
      else if (strb.statRead) thermChg <= 1'b0;

      if (fanEv)                         fanChg <= 1'b1;
      else if (strb.statRead || fanEnd)  fanChg <= 1'b0;

      if (irqClear)   evLatch <= 1'b0;
      else if (evSet) evLatch <= 1'b1;
    end
  end

  always_comb begin
    statAnPad   = '0;
    statFanPad  = '0;
    statGpioPad = '0;
    statAnPad[NUM_AN-1:0]     = statAn;
    statFanPad[NUM_FAN-1:0]   = statFan;
    statGpioPad[NUM_GPIO-1:0] = gpioIn;
    statMisc = '0;
    statMisc[MISC_THERM]  = thermChg;
    statMisc[MISC_FANCHG] = fanChg;
    statMisc[MISC_INTR]   = intrusion;
    statMisc[MISC_GPIOHI] = gpioHi;
  end

  always_comb begin
    case (addr)
      A_CFG:       rdData = cfgReg;
      A_STAT_AN:   rdData = statAnPad;
      A_STAT_FAN:  rdData = statFanPad;
      A_STAT_MISC: rdData = statMisc;
      A_STAT_GPIO: rdData = statGpioPad;
      A_MASK_AN:   rdData = maskAn;
      A_MASK_FAN:  rdData = maskFan;
      A_MASK_MISC: rdData = maskMisc;
      A_MASK_GPIO: rdData = maskGpio;
      default:     rdData = '0;
    endcase
  end

  assign levelIrq = (|(gpioIn & ~maskGpio[NUM_GPIO-1:0])) |
                    (intrusion & ~maskMisc[MISC_INTR]) |
                    (gpioHi & ~maskMisc[MISC_GPIOHI]);
  assign pending  = anLatch | fanLatch | evLatch | levelIrq;
  assign irqN     = ~(cfgReg[CFG_EN] & ~cfgReg[CFG_CLR] & pending);
endmodule

// File: rtl/mon_irq_agg.sv
module mon_irq_agg
  import mon_irq_pkg::*;
#(
  parameter int         NUM_AN   = 8,
  parameter int         NUM_FAN  = 8,
  parameter int         NUM_GPIO = 8,
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [3:0]          addr,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  input  logic                analogEnd,
  input  logic [NUM_AN-1:0]   analogOor,
  input  logic                fanEnd,
  input  logic [NUM_FAN-1:0]  fanSlow,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  logic                gpioHi,
  input  logic                intrusion,
  input  logic                thermIn,
  input  logic                fanRunning,
  input  logic                araValid,
  input  logic [6:0]          araAddr,
  output logic                irqN
);
  ctrl_strobe_t strb;

  mon_irq_ctrl #(.ARA_ADDR(ARA_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .araValid(araValid), .araAddr(araAddr), .thermIn(thermIn),
    .fanRunning(fanRunning), .strb(strb)
  );

  mon_irq_dp #(.NUM_AN(NUM_AN), .NUM_FAN(NUM_FAN), .NUM_GPIO(NUM_GPIO)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .analogEnd(analogEnd), .analogOor(analogOor),
    .fanEnd(fanEnd), .fanSlow(fanSlow), .gpioIn(gpioIn), .gpioHi(gpioHi),
    .intrusion(intrusion), .irqN(irqN)
  );
endmodule

// File: rtl/mon_irq_chk.sv
module mon_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       rdEn,
  input logic [3:0] addr,
  input logic       araValid,
  input logic [6:0] araAddr,
  input logic       fanEnd,
  input logic       intrusion,
  input logic       irqN,
  input logic       cfgEn,
  input logic       cfgClr,
  input logic       maskIntr,
  input logic       anLatch,
  input logic       fanLatch,
  input logic       evLatch,
  input logic       anArmed,
  input logic       fanArmed,
  input logic       fanChg,
  input logic       fanEdge
);
  p_gate_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfgEn || cfgClr) |-> irqN);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == 4'd1) |=> (!anLatch && !fanLatch && !evLatch));

  p_ara_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (araValid && araAddr == 7'b0001100) |=> (!anLatch && !fanLatch && !evLatch));

  p_an_first_end_r8: assert property (@(posedge clk) disable iff (rst)
    (!anArmed && !anLatch) |=> !anLatch);

  p_fan_first_end_r8: assert property (@(posedge clk) disable iff (rst)
    (!fanArmed && !fanLatch) |=> !fanLatch);

  p_level_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (intrusion && !maskIntr && cfgEn && !cfgClr) |-> !irqN);

  p_fanchg_expires_r11: assert property (@(posedge clk) disable iff (rst)
    (fanEnd && !fanEdge) |=> !fanChg);
endmodule

bind mon_irq_agg mon_irq_chk u_chk (
  .clk(clk), .rst(rst), .rdEn(rdEn), .addr(addr), .araValid(araValid),
  .araAddr(araAddr), .fanEnd(fanEnd), .intrusion(intrusion), .irqN(irqN),
  .cfgEn(u_dp.cfgReg[1]), .cfgClr(u_dp.cfgReg[2]), .maskIntr(u_dp.maskMisc[6]),
  .anLatch(u_dp.anLatch), .fanLatch(u_dp.fanLatch), .evLatch(u_dp.evLatch),
  .anArmed(u_dp.anArmed), .fanArmed(u_dp.fanArmed), .fanChg(u_dp.fanChg),
  .fanEdge(u_ctrl.strb.fanEdge)
);

// File: tb/sim_mon_irq_agg.sv
module sim_mon_irq_agg;
  logic clk = 1'b0, rst = 1'b1;
  logic wrEn = 0, rdEn = 0, analogEnd = 0, fanEnd = 0;
  logic gpioHi = 0, intrusion = 0, thermIn = 0, fanRunning = 0, araValid = 0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0, rdData, analogOor = '0, fanSlow = '0, gpioIn = '0;
  logic [6:0] araAddr = '0;
  logic irqN;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] d;

  always #2 clk = ~clk;

  mon_irq_agg u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .analogEnd(analogEnd), .analogOor(analogOor), .fanEnd(fanEnd),
    .fanSlow(fanSlow), .gpioIn(gpioIn), .gpioHi(gpioHi), .intrusion(intrusion),
    .thermIn(thermIn), .fanRunning(fanRunning), .araValid(araValid),
    .araAddr(araAddr), .irqN(irqN)
  );

  // entry: analog, fan, gpio, pin expected low
  localparam logic [24:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 1'b0}, {8'h10, 8'h00, 8'h00, 1'b0},
    {8'h01, 8'h00, 8'h00, 1'b1}, {8'h00, 8'h0F, 8'h00, 1'b0},
    {8'h00, 8'h20, 8'h00, 1'b1}, {8'h00, 8'h00, 8'hAA, 1'b0},
    {8'h00, 8'h00, 8'h04, 1'b1}, {8'hF0, 8'h0F, 8'hAA, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pin(input string req, input logic expLow);
    chk(req, {7'b0, irqN}, {7'b0, ~expLow});
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); wrEn = 1; addr = a; wrData = v;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rdEn = 1; addr = a; #1 v = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic pulseA(); @(negedge clk); analogEnd = 1; @(negedge clk); analogEnd = 0; endtask
  task automatic pulseF(); @(negedge clk); fanEnd = 1; @(negedge clk); fanEnd = 0; endtask
  task automatic pulseBoth();
    @(negedge clk); analogEnd = 1; fanEnd = 1;
    @(negedge clk); analogEnd = 0; fanEnd = 0;
  endtask

  task automatic ara(input logic [6:0] a);
    @(negedge clk); araValid = 1; araAddr = a;
    @(negedge clk); araValid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    pin("R1 pin idle after reset", 1'b0);
    rd(4'd0, d); chk("R1 cfg reset", d, 8'h00);
    rd(4'd3, d); chk("R1 misc status reset", d, 8'h00);
    rd(4'd8, d); chk("R1 gpio mask reset", d, 8'h00);

    wr(4'd8, 8'hAA); rd(4'd8, d); chk("R13 gpio mask readback", d, 8'hAA);
    wr(4'd5, 8'hF0); rd(4'd5, d); chk("R13 analog mask readback", d, 8'hF0);
    wr(4'd6, 8'h0F); wr(4'd0, 8'h02);
    rd(4'd0, d); chk("R13 cfg readback", d, 8'h02);

    for (int i = 0; i < 8; i++) begin
      analogOor = VEC[i][24:17]; fanSlow = VEC[i][16:9]; gpioIn = VEC[i][8:1];
      rd(4'd1, d);
      pulseBoth(); pulseBoth();
      pin($sformatf("R3 R4 R12 table entry %0d pin", i), VEC[i][0]);
      rd(4'd4, d); chk($sformatf("R9 table entry %0d gpio status", i), d, VEC[i][8:1]);
      rd(4'd2, d); chk($sformatf("R4 table entry %0d fan status", i), d, VEC[i][16:9]);
      rd(4'd1, d); chk($sformatf("R3 table entry %0d analog status", i), d, VEC[i][24:17]);
    end
    analogOor = 0; fanSlow = 0; gpioIn = 0;
    rd(4'd1, d);
    wr(4'd5, 8'h00); wr(4'd6, 8'h00);

    analogOor = 8'h01;
    rd(4'd1, d);
    pulseA(); pin("R8 first analog end after clear discarded", 1'b0);
    pulseA(); pin("R3 second analog end sets latch", 1'b1);

    ara(7'h0D); pin("R6 wrong alert address ignored", 1'b1);
    ara(7'h0C); pin("R6 alert address clears", 1'b0);

    wr(4'd0, 8'h06);
    pulseA(); pulseA(); pin("R7 clear bit holds pin high", 1'b0);
    wr(4'd0, 8'h02); pin("R8 disarmed after clear bit drops", 1'b0);
    pulseA(); pulseA(); pin("R8 rearmed after two ends", 1'b1);
    wr(4'd0, 8'h00); pin("R2 enable low blocks pin", 1'b0);
    wr(4'd0, 8'h02); pin("R2 enable high restores pin", 1'b1);
    analogOor = 0;
    rd(4'd1, d); pin("R5 status read clears pin", 1'b0);
    pulseA(); pulseA();

    fanSlow = 8'h01;
    pulseF(); pulseF(); pin("R4 fan latch drives pin", 1'b1);
    rd(4'd2, d); chk("R4 fan status", d, 8'h01);
    rd(4'd1, d); pin("R5 status read clears fan latch", 1'b0);
    rd(4'd2, d); chk("R5 fan status cleared", d, 8'h00);
    fanSlow = 0;

    intrusion = 1; tick(); pin("R9 intrusion level", 1'b1);
    rd(4'd3, d); chk("R9 intrusion status bit 6", d, 8'h40);
    rd(4'd1, d); pin("R9 read does not clear level", 1'b1);
    ara(7'h0C); pin("R9 alert does not clear level", 1'b1);
    wr(4'd7, 8'h40); pin("R9 masked intrusion releases", 1'b0);
    wr(4'd7, 8'h00); pin("R9 unmasked intrusion returns", 1'b1);
    intrusion = 0; tick(); pin("R9 removed intrusion releases", 1'b0);
    gpioHi = 1; tick(); pin("R9 high gpio level", 1'b1);
    rd(4'd3, d); chk("R9 high gpio status bit 7", d, 8'h80);
    gpioHi = 0; tick(); pin("R9 high gpio removed", 1'b0);

    thermIn = 1; tick(); pin("R10 thermal rise event", 1'b1);
    rd(4'd3, d); chk("R10 thermal status bit 3", d, 8'h08);
    rd(4'd1, d); tick(); tick(); tick();
    pin("R10 steady thermal no reassert", 1'b0);
    rd(4'd3, d); chk("R10 thermal bit cleared by read", d, 8'h00);
    thermIn = 0; tick(); pin("R10 thermal fall event", 1'b1);
    rd(4'd1, d);

    wr(4'd7, 8'h08);
    thermIn = 1; tick(); pin("R12 masked thermal event", 1'b0);
    rd(4'd3, d); chk("R12 masked event still recorded", d, 8'h08);
    wr(4'd7, 8'h00); rd(4'd1, d);

    fanRunning = 1; tick(); pin("R11 fan edge ignored without auto control", 1'b0);
    rd(4'd3, d); chk("R11 fan change bit stays clear", d, 8'h00);
    wr(4'd0, 8'h12);
    fanRunning = 0; tick(); pin("R11 fan stop event", 1'b1);
    rd(4'd3, d); chk("R11 fan change bit 4", d, 8'h10);
    pulseF();
    rd(4'd3, d); chk("R11 fan change expires at fan end", d, 8'h00);
    pin("R11 event latch held until clear", 1'b1);
    rd(4'd1, d); pin("R5 read clears event latch", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule